// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per N input cycles, which drives the feedback side of a phase detector. The ratio is set by three fields: a prescaler select that picks the base modulus P (8, 16, 32 or 64), a 13-bit main count B and a 6-bit swallow count A. The result is N = B·P + A. Because A can be any value from 0 up to P−1 without passing B, every integer N from P²−P upward can be reached.

The prescaler is a synchronous divide-by-4/5 core followed by a binary extension stage. Within one divide cycle it runs A periods of P+1 input cycles, then B−A periods of P input cycles. The swallow counter sets the modulus control. The main counter marks the end of the cycle. At that end both counters and the prescaler select reload from the inputs. Changes on the inputs therefore never shorten or stretch a cycle that is already running. A setting with A larger than B raises an error flag. In that case A is taken as equal to B, so the output stays periodic.

Top module: `psw_divider`

## Requirements
- R1: With A ≤ B and B ≥ 3, the interval between successive output pulses is exactly B·P + A input clock cycles.
- R2: The prescaler select encodes the base modulus as 00 → 8, 01 → 16, 10 → 32, 11 → 64.
- R3: Each output pulse is high for exactly one clock cycle.
- R4: A swallow count of 0 gives N = B·P. The largest swallow count, 63, adds 63 cycles.
- R5: A main count below 3 (including 0) is treated as 3.
- R6: If A exceeds the main count in use, `cfg_err` is high for the whole divide cycle loaded with that setting, and that cycle lasts B·(P+1).
- R7: Values on the select, B and A inputs are sampled only at the end of a divide cycle. A change made mid-cycle changes neither the current interval nor `cfg_err` until the next reload.
- R8: While `rst_n` is low, `div_pulse` and `cfg_err` are low. Asserting reset in the middle of a run clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 2 | Base modulus select (00=8, 01=16, 10=32, 11=64) |
| b_cnt | input | 13 | Main count B |
| a_cnt | input | 6 | Swallow count A |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | High during a divide cycle loaded with A greater than B |

## Verification
Two events can fall on the same clock edge: the end-of-cycle reload, and the swallow start or error update of the next cycle. At that edge the counters reload, the core chooses a /5 or /4 first pass, and `cfg_err` takes its new value. The bench provokes this by changing the settings on the cycle right after a pulse, and also part-way through a cycle. It judges the result by counting input cycles between pulses and by sampling `cfg_err` before and at the following pulse. It expects the old ratio for the running cycle and the new ratio and error state only from the next reload on.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int SEL_W   = 2;
  localparam int CORE_MOD = 4;               // base divide of the 4/5 core
  localparam int CORE_W  = 3;                // holds 0..CORE_MOD
  localparam int K_MIN   = 1;                // P = CORE_MOD * 2**k, smallest P = 8
  localparam int K_MAX   = K_MIN + (1 << SEL_W) - 1;
  localparam int K_W     = $clog2(K_MAX + 1);
  localparam int EXT_W   = K_MAX;            // extension counts 0 .. 2**k-1

  function automatic logic [K_W-1:0] sel_to_k(input logic [SEL_W-1:0] sel);
    return K_W'(sel) + K_W'(K_MIN);
  endfunction
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mc_next,   // next period divides by P+1
  input  logic [K_W-1:0] k_next,    // extension exponent for next period
  output logic           pre_tick
);
  logic [CORE_W-1:0] core_q, core_d;
  logic [EXT_W-1:0]  ext_q, ext_d;
  logic [EXT_W-1:0]  ext_load;
  logic              core_tick;

  always_comb begin
    core_tick = (core_q == '0);
    pre_tick  = core_tick && (ext_q == '0);
    ext_load  = EXT_W'((32'd1 << k_next) - 32'd1);
    core_d    = core_q;
    ext_d     = ext_q;
    if (core_tick) begin
      // the first core pass of a period swallows one extra cycle when asked
      core_d = (pre_tick && mc_next) ? CORE_W'(CORE_MOD) : CORE_W'(CORE_MOD - 1);
      ext_d  = (ext_q == '0) ? ext_load : ext_q - 1'b1;
    end else begin
      core_d = core_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      ext_q  <= '0;
    end else begin
      core_q <= core_d;
      ext_q  <= ext_d;
    end
  end

  p_core_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_q <= CORE_W'(CORE_MOD));
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int B_W   = 13,
  parameter int A_W   = 6,
  parameter int B_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [SEL_W-1:0] psel,
  input  logic [B_W-1:0]   b_in,
  input  logic [A_W-1:0]   a_in,
  output logic             mc_next,
  output logic [K_W-1:0]   k_next,
  output logic             div_pulse,
  output logic             cfg_err
);
  logic [A_W-1:0] a_rem_q, a_rem_d;
  logic [B_W-1:0] b_rem_q, b_rem_d;
  logic [K_W-1:0] k_q, k_d;
  logic           err_q, err_d;
  logic           run_q, run_d;
  logic           pulse_q, pulse_d;

  logic [B_W-1:0] b_eff;
  logic [A_W-1:0] a_eff;
  logic           a_big;
  logic           last_period;
  logic           boundary;

  always_comb begin
    b_eff       = (b_in < B_W'(B_MIN)) ? B_W'(B_MIN) : b_in;
    a_big       = B_W'(a_in) > b_eff;
    a_eff       = a_big ? b_eff[A_W-1:0] : a_in;
    last_period = (b_rem_q <= B_W'(1));
    boundary    = pre_tick && last_period;

    a_rem_d = a_rem_q;
    b_rem_d = b_rem_q;
    k_d     = k_q;
    err_d   = err_q;
    run_d   = run_q;
    if (boundary) begin
      a_rem_d = a_eff;
      b_rem_d = b_eff;
      k_d     = sel_to_k(psel);
      err_d   = a_big;
      run_d   = 1'b1;
    end else if (pre_tick) begin
      b_rem_d = b_rem_q - 1'b1;
      a_rem_d = (a_rem_q != '0) ? a_rem_q - 1'b1 : a_rem_q;
    end
    pulse_d = boundary && run_q;
    mc_next = (a_rem_d != '0);
    k_next  = k_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem_q <= '0;
      b_rem_q <= B_W'(1);
      k_q     <= K_W'(K_MIN);
      err_q   <= 1'b0;
      run_q   <= 1'b0;
    end else if (pre_tick) begin
      a_rem_q <= a_rem_d;
      b_rem_q <= b_rem_d;
      k_q     <= k_d;
      err_q   <= err_d;
      run_q   <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign div_pulse = pulse_q;
  assign cfg_err   = err_q;

  p_swallow_within_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(a_rem_q) <= b_rem_q);
  p_main_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (b_rem_q >= B_W'(B_MIN)));
  p_err_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(err_q));
  p_k_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (k_q >= K_W'(K_MIN)) && (k_q <= K_W'(K_MAX)));
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int B_W        = 13,
  parameter int A_W        = 6,
  parameter int B_MIN      = 3,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psel,
  input  logic [B_W-1:0]   b_cnt,
  input  logic [A_W-1:0]   a_cnt,
  output logic             div_pulse,
  output logic             cfg_err
);
  logic           rst_n_int;
  logic           pre_tick;
  logic           mc_next;
  logic [K_W-1:0] k_next;

  psw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  psw_prescaler u_pre (
    .clk(clk), .rst_n(rst_n_int), .mc_next(mc_next), .k_next(k_next),
    .pre_tick(pre_tick)
  );

  psw_ctrl #(.B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .pre_tick(pre_tick), .psel(psel),
    .b_in(b_cnt), .a_in(a_cnt), .mc_next(mc_next), .k_next(k_next),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    div_pulse |=> !div_pulse);
  p_pulse_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(div_pulse) |-> $past(pre_tick));
endmodule

// File: tb/psw_divider_tb.sv
module psw_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  psel;
  logic [12:0] b_cnt;
  logic [5:0]  a_cnt;
  logic        div_pulse;
  logic        cfg_err;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  psw_divider u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .b_cnt(b_cnt), .a_cnt(a_cnt),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  // {psel[41:40], b[39:27], a[26:21], expected N[20:1], expected err[0]}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 13'd3,  6'd0,  20'd24,   1'b0},  // R1 R4 smallest
    {2'd0, 13'd3,  6'd3,  20'd27,   1'b0},  // R1 A = B
    {2'd1, 13'd5,  6'd2,  20'd82,   1'b0},  // R2 16
    {2'd2, 13'd4,  6'd1,  20'd129,  1'b0},  // R2 32
    {2'd3, 13'd3,  6'd0,  20'd192,  1'b0},  // R2 64
    {2'd3, 13'd4,  6'd4,  20'd260,  1'b0},  // R1
    {2'd0, 13'd10, 6'd7,  20'd87,   1'b0},  // R1
    {2'd1, 13'd2,  6'd0,  20'd48,   1'b0},  // R5 B=2 -> 3
    {2'd0, 13'd4,  6'd9,  20'd36,   1'b1},  // R6
    {2'd2, 13'd63, 6'd63, 20'd2079, 1'b0},  // R4 A max
    {2'd3, 13'd10, 6'd63, 20'd650,  1'b1},  // R6
    {2'd0, 13'd0,  6'd0,  20'd24,   1'b0}   // R5 B=0 -> 3
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <=190000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
    end while (!div_pulse && n < 100000);
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [12:0] b, input logic [5:0] a);
    psel = s; b_cnt = b; a_cnt = a;
  endtask

  initial begin
    int n, n1, n2;
    rst_n = 1'b0;
    set_cfg(2'd0, 13'd4, 6'd9);
    repeat (3) begin
      @(negedge clk);
      check("R8 pulse in reset", int'(div_pulse), 0);
      check("R8 err in reset", int'(cfg_err), 0);
    end
    rst_n = 1'b1;
    set_cfg(2'd0, 13'd3, 6'd0);
    wait_pulse(n);

    // table walk: first pulse loads the setting, second closes a cycle with it
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][41:40], VEC[i][39:27], VEC[i][26:21]);
      wait_pulse(n);
      wait_pulse(n);
      check($sformatf("R1/R2/R4/R5/R6 period vec%0d", i), n, int'(VEC[i][20:1]));
      check($sformatf("R6 err vec%0d", i), int'(cfg_err), int'(VEC[i][0]));
    end

    // R3: single-cycle pulse
    set_cfg(2'd0, 13'd3, 6'd0);
    wait_pulse(n);
    wait_pulse(n);
    @(negedge clk);
    check("R3 pulse width", int'(div_pulse), 0);

    // R7: mid-cycle change keeps current interval and err
    wait_pulse(n);
    repeat (5) @(negedge clk);
    set_cfg(2'd1, 13'd5, 6'd2);
    wait_pulse(n1);
    check("R7 current interval unchanged", n1 + 5, 24);
    wait_pulse(n2);
    check("R7 new interval after reload", n2, 82);

    set_cfg(2'd0, 13'd3, 6'd0);
    wait_pulse(n);
    wait_pulse(n);
    repeat (3) @(negedge clk);
    set_cfg(2'd0, 13'd4, 6'd9);
    repeat (2) @(negedge clk);
    check("R7 err not updated mid-cycle", int'(cfg_err), 0);
    wait_pulse(n);
    check("R7 interval before reload", n + 5, 24);
    check("R6 err after reload", int'(cfg_err), 1);

    // R8: reset in mid-run clears err
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 err cleared by reset", int'(cfg_err), 0);
    check("R8 pulse cleared by reset", int'(div_pulse), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    set_cfg(2'd0, 13'd3, 6'd0);
    wait_pulse(n);

    // R1: largest main count
    set_cfg(2'd0, 13'd8191, 6'd5);
    wait_pulse(n);
    wait_pulse(n);
    check("R1 large B period", n, 65533);
    check("R6 err low large B", int'(cfg_err), 0);

    finish_run();
  end
endmodule